// File: doc/BRIEF.md
# UART Register Front-End

This block sits between a 32-bit word-addressed register bus and the serial shift logic of one UART channel. Software programs the channel through a small set of registers: a control register, a character mode register, two baud setting registers and a read-only channel status word. A single data port gives access to both queues. A bus write to that port appends a byte to the transmit queue. A bus read from it removes the oldest byte from the receive queue.

The serializer drains the transmit queue through a valid/pop pair. The deserializer fills the receive queue through a push strobe. The block drives enable levels for both paths and a one-cycle flush strobe for each path. The mode and baud values are passed through as plain outputs, because timing and framing live outside this block.

Top module: `uart_regfront`

## Requirements
- R1: After reset, control reads 0x00, mode reads 0x000, baud generator reads 0x028B, baud divider reads 0x0F, and status reads 0x0A (both queues empty).
- R2: A write to control (byte offset 0x00) stores bit 4 as transmit enable and bit 2 as receive enable. Both appear on `tx_enable` and `rx_enable` from the next cycle. A control read returns only those two bits, and bits 1 and 0 always read as 0.
- R3: A control write with bit 1 set empties the transmit queue at that clock edge and raises `tx_flush` for exactly the following cycle. Bit 0 does the same for the receive queue and `rx_flush`. When the reset bits are written together with the enable bits, both queues come out empty and both paths come out enabled.
- R4: A write to the data offset 0x30 appends `wdata[7:0]` to the transmit queue. If the queue is full, the write is dropped and the queued contents stay unchanged.
- R5: `tx_valid` is high when the transmit queue holds data and transmit is enabled. `tx_data` shows the oldest byte. `tx_pop` removes that byte only while `tx_valid` is high, and is ignored otherwise.
- R6: `rx_push` stores `rx_din` in the receive queue only when receive is enabled and the queue is not full. Otherwise the push is ignored.
- R7: A read from the data offset 0x30 returns the oldest received byte, zero-extended, and removes it. A read while the queue is empty returns 0 and removes nothing.
- R8: Status (offset 0x2C) reports bit 0 = receive queue full, bit 1 = receive queue empty, bit 3 = transmit queue empty and bit 4 = transmit queue full. All other bits read as 0.
- R9: Mode (0x04) holds 11 bits, baud generator (0x18) holds 16 bits and baud divider (0x34) holds 8 bits. Each reads back the written value truncated to its width and drives its output port. Mode value 0x20 selects 8-bit characters with no parity.
- R10: Reserved offsets read as 0 and ignore writes. Writes to the status offset change nothing.
- R11: Each queue holds exactly 64 bytes in first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 6 | Byte address; bits 5:2 select the word |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, valid in the cycle of `rd_en` |
| tx_enable | output | 1 | Transmit path enable |
| rx_enable | output | 1 | Receive path enable |
| tx_flush | output | 1 | One-cycle transmit path reset strobe |
| rx_flush | output | 1 | One-cycle receive path reset strobe |
| mode_cfg | output | 11 | Character mode setting |
| baud_gen | output | 16 | Baud generator count |
| baud_div | output | 8 | Baud divider value |
| tx_valid | output | 1 | Transmit byte available to the serializer |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_din | input | 8 | Received byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The hardest state to reach from the ports is a completely full queue that then receives one more byte. The bench must issue 64 separate bus writes, or 64 deserializer pushes, with no drain in between. It then offers a marker byte, and afterwards drains all 64 entries and confirms that the marker never appears. A second case combines the flush and enable bits in one control write while a queue holds data. This shows that the flush and the enable update land in the same edge, and that the flush strobe lasts exactly one cycle.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [5:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          tx_enable,
  output logic          rx_enable,
  output logic          tx_flush,
  output logic          rx_flush,
  output logic [10:0]   mode_cfg,
  output logic [15:0]   baud_gen,
  output logic [7:0]    baud_div,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_pop,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [3:0] W_CTRL = 4'h0;
  localparam logic [3:0] W_MODE = 4'h1;
  localparam logic [3:0] W_BGEN = 4'h6;
  localparam logic [3:0] W_STAT = 4'hB;
  localparam logic [3:0] W_DATA = 4'hC;
  localparam logic [3:0] W_BDIV = 4'hD;

  logic [3:0] word;
  assign word = addr[5:2];

  logic ctrl_wr, tx_rst, rx_rst, tx_push, tx_take, rx_accept, rx_take;
  assign ctrl_wr   = wr_en && word == W_CTRL;
  assign tx_rst    = ctrl_wr && wdata[1];
  assign rx_rst    = ctrl_wr && wdata[0];
  assign tx_push   = wr_en && word == W_DATA && !tx_full;
  assign tx_take   = tx_pop && tx_valid;
  assign rx_accept = rx_push && rx_enable && !rx_full;
  assign rx_take   = rd_en && word == W_DATA && !rx_empty;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[31:16]};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_enable <= 1'b0;
      rx_enable <= 1'b0;
      tx_flush  <= 1'b0;
      rx_flush  <= 1'b0;
      mode_cfg  <= '0;
      baud_gen  <= 16'h028B;
      baud_div  <= 8'h0F;
    end else begin
      tx_flush <= tx_rst;
      rx_flush <= rx_rst;
      if (ctrl_wr) begin
        tx_enable <= wdata[4];
        rx_enable <= wdata[2];
      end
      if (wr_en && word == W_MODE) mode_cfg <= wdata[10:0];
      if (wr_en && word == W_BGEN) baud_gen <= wdata[15:0];
      if (wr_en && word == W_BDIV) baud_div <= wdata[7:0];
    end
  end

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW:0]   tx_wp, tx_rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else if (tx_rst) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_take) tx_rp <= tx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= wdata[DW-1:0];

  assign tx_empty = tx_wp == tx_rp;
  assign tx_full  = tx_wp[AW] != tx_rp[AW] && tx_wp[AW-1:0] == tx_rp[AW-1:0];
  assign tx_valid = !tx_empty && tx_enable;
  assign tx_data  = tx_mem[tx_rp[AW-1:0]];

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW:0]   rx_wp, rx_rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else if (rx_rst) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (rx_accept) rx_wp <= rx_wp + 1'b1;
      if (rx_take)   rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (rx_accept) rx_mem[rx_wp[AW-1:0]] <= rx_din;

  assign rx_empty = rx_wp == rx_rp;
  assign rx_full  = rx_wp[AW] != rx_rp[AW] && rx_wp[AW-1:0] == rx_rp[AW-1:0];

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (word)
        W_CTRL: rdata = {27'd0, tx_enable, 1'b0, rx_enable, 2'b00};
        W_MODE: rdata = {21'd0, mode_cfg};
        W_BGEN: rdata = {16'd0, baud_gen};
        W_STAT: rdata = {27'd0, tx_full, tx_empty, 1'b0, rx_empty, rx_full};
        W_DATA: rdata = rx_empty ? 32'd0 : {{(32-DW){1'b0}}, rx_mem[rx_rp[AW-1:0]]};
        W_BDIV: rdata = {24'd0, baud_div};
        default: rdata = '0;
      endcase
    end
  end

  AST_TXRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) tx_rst |=> tx_empty); // R3
  AST_RXRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) rx_rst |=> rx_empty); // R3
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_en && word == W_DATA && !tx_pop) |=> tx_full); // R4
  AST_RX_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_enable && !rx_rst) |=> $stable(rx_wp)); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == W_DATA && rx_empty) |-> rdata == 32'd0); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R8
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_enable, rx_enable, tx_flush, rx_flush;
  logic [10:0] mode_cfg;
  logic [15:0] baud_gen;
  logic [7:0]  baud_div;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_din = '0;
  logic        tx_full, tx_empty, rx_full, rx_empty;

  int checks = 0;
  int errors = 0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .mode_cfg(mode_cfg),
    .baud_gen(baud_gen), .baud_div(baud_div), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_din(rx_din),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); d = tx_data; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_din = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic t_reset;
    rd(6'h00, got); chk("R1 ctrl", got, 32'h0);
    rd(6'h04, got); chk("R1 mode", got, 32'h0);
    rd(6'h18, got); chk("R1 bgen", got, 32'h028B);
    rd(6'h34, got); chk("R1 bdiv", got, 32'h0F);
    rd(6'h2C, got); chk("R1 R8 status", got, 32'h0A);
  endtask

  task automatic t_regs;
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, got); chk("R9 mode mask", got, 32'h7FF);
    wr(6'h04, 32'h20); rd(6'h04, got); chk("R9 mode 8N", got, 32'h20);
    chk("R9 mode port", {21'd0, mode_cfg}, 32'h20);
    wr(6'h18, 32'h0001_2345); rd(6'h18, got); chk("R9 bgen", got, 32'h2345);
    wr(6'h34, 32'h1FF); rd(6'h34, got); chk("R9 bdiv", got, 32'hFF);
    chk("R9 bdiv port", {24'd0, baud_div}, 32'hFF);
  endtask

  task automatic t_reserved;
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, got); chk("R10 reserved", got, 32'h0);
    wr(6'h3C, 32'hFFFF_FFFF); rd(6'h3C, got); chk("R10 reserved top", got, 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF); rd(6'h2C, got); chk("R10 status write", got, 32'h0A);
    rd(6'h00, got); chk("R10 ctrl untouched", got, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(6'h00, 32'h17);
    chk("R3 tx_flush high", {31'd0, tx_flush}, 32'h1);
    chk("R3 rx_flush high", {31'd0, rx_flush}, 32'h1);
    chk("R2 enables", {30'd0, tx_enable, rx_enable}, 32'h3);
    @(negedge clk);
    chk("R3 flush one cycle", {30'd0, tx_flush, rx_flush}, 32'h0);
    rd(6'h00, got); chk("R2 ctrl readback", got, 32'h14);
  endtask

  task automatic t_tx_order;
    logic [7:0] b;
    wr(6'h30, 32'h41); wr(6'h30, 32'h42); wr(6'h30, 32'h43); wr(6'h30, 32'h1FF);
    chk("R5 tx_valid", {31'd0, tx_valid}, 32'h1);
    pop(b); chk("R5 R4 head", {24'd0, b}, 32'h41);
    pop(b); chk("R5 second", {24'd0, b}, 32'h42);
    pop(b); chk("R5 third", {24'd0, b}, 32'h43);
    pop(b); chk("R4 low byte", {24'd0, b}, 32'hFF);
    chk("R5 drained", {31'd0, tx_valid}, 32'h0);
    rd(6'h2C, got); chk("R8 tx empty", got, 32'h0A);
  endtask

  task automatic t_tx_full;
    logic [7:0] b;
    int bad = 0;
    wr(6'h30, 32'h77);
    wr(6'h00, 32'h16);
    rd(6'h2C, got); chk("R3 tx flushed", got[4:3], 32'h1);
    for (int i = 0; i < 64; i++) wr(6'h30, 32'(i + 1));
    rd(6'h2C, got); chk("R11 R8 tx full", got[4:3], 32'h2);
    wr(6'h30, 32'hEE);
    for (int i = 0; i < 64; i++) begin
      pop(b);
      if (b != 8'(i + 1)) bad++;
    end
    chk("R11 R4 order no overflow", 32'(bad), 32'h0);
    chk("R4 dropped byte absent", {31'd0, tx_empty}, 32'h1);
  endtask

  task automatic t_tx_gate;
    logic [7:0] b;
    wr(6'h30, 32'h55);
    wr(6'h00, 32'h04);
    chk("R5 disabled valid", {31'd0, tx_valid}, 32'h0);
    pop(b);
    wr(6'h00, 32'h14);
    chk("R5 pop ignored", {23'd0, tx_valid, tx_data}, 32'h155);
    pop(b);
  endtask

  task automatic t_rx;
    push(8'h10); push(8'h20);
    rd(6'h2C, got); chk("R8 rx nonempty", got[1:0], 32'h0);
    rd(6'h30, got); chk("R7 oldest", got, 32'h10);
    rd(6'h30, got); chk("R7 next", got, 32'h20);
    rd(6'h30, got); chk("R7 empty read", got, 32'h0);
    push(8'h30);
    rd(6'h30, got); chk("R7 no pointer move", got, 32'h30);
  endtask

  task automatic t_rx_disabled;
    wr(6'h00, 32'h10);
    push(8'h99);
    rd(6'h2C, got); chk("R6 disabled push", got[1:0], 32'h2);
    wr(6'h00, 32'h14);
    rd(6'h30, got); chk("R6 nothing stored", got, 32'h0);
  endtask

  task automatic t_rx_full;
    int bad = 0;
    for (int i = 0; i < 64; i++) push(8'(8'h80 + i));
    rd(6'h2C, got); chk("R11 R8 rx full", got[1:0], 32'h1);
    push(8'hAA);
    for (int i = 0; i < 64; i++) begin
      rd(6'h30, got);
      if (got != 32'(8'h80 + i)) bad++;
    end
    chk("R11 R6 rx order", 32'(bad), 32'h0);
    rd(6'h30, got); chk("R6 extra dropped", got, 32'h0);
  endtask

  task automatic t_rx_reset;
    push(8'h01); push(8'h02); push(8'h03);
    wr(6'h00, 32'h15);
    rd(6'h2C, got); chk("R3 rx flushed", got[1:0], 32'h2);
    rd(6'h00, got); chk("R3 enabled after reset", got, 32'h14);
    push(8'h42);
    rd(6'h30, got); chk("R3 rx usable", got, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_reserved;
    t_ctrl;
    t_tx_order;
    t_tx_full;
    t_tx_gate;
    t_rx;
    t_rx_disabled;
    t_rx_full;
    t_rx_reset;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule